// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block interprets the write cycles a host issues to a parallel NOR-style flash device. Each write carries a word address and a 16-bit data word. The decoder follows the multi-write unlock handshakes and turns each completed command into a one-clock strobe for the embedded-operation engine. The strobes cover single-word programming (with address and data), write-buffer load start and abort reset. A write that breaks a sequence, or that names a command the current mode rejects, raises an error strobe. The decoder then returns to the idle point of its current mode.

A bypass mode removes the two unlock writes from programming. The host enters it with a three-write sequence and leaves it with a two-write sequence. While bypass is active, only a small set of commands is legal. An acceleration input also forces the decoder into bypass. Releasing that input drops back to normal operation once the embedded operation has finished. A busy input from the operation engine blocks every new command except the abort reset.

The write port is a valid/ready stream that never applies back-pressure. `wr_ready` stays high, and a write is taken on every clock edge where `wr_valid` is high. The decoder has no queue of its own. The engine that consumes the strobes must sample them on the cycle they appear.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, all strobes are low, `bypass_mode` is low, and `wr_ready` is high at all times.
- R2: In normal mode, a single-word program is four writes: AAh at 555h, 55h at 2AAh, A0h at 555h, then the target write. One cycle after the fourth write, `pgm_stb` pulses with that write's address and full data word. The first three writes produce no strobe.
- R3: In normal mode, the writes AAh at 555h, 55h at 2AAh and 20h at 555h set `bypass_mode` one cycle after the third write.
- R4: In bypass mode, a program is two writes: A0h at any address, then the target write. `pgm_stb` pulses one cycle after the second write.
- R5: In bypass mode, 90h at any address followed by 00h at any address clears `bypass_mode`. If the second write is anything other than 00h, it raises `err_stb` and bypass stays on.
- R6: In bypass mode, the only legal first writes are A0h, 25h, 90h, and AAh at 555h. Any other first write, including a lone F0h, raises `err_stb` and no command strobe.
- R7: In bypass mode, an abort reset needs AAh at 555h, 55h at 2AAh, then F0h. It pulses `abort_stb` and leaves bypass on.
- R8: In normal mode, a lone F0h at any address pulses `abort_stb`. So does F0h written as the third write after the two unlock writes.
- R9: A write-buffer load start pulses `bufld_stb` with the address of the 25h write. In normal mode, 25h is the third write after the unlocks. In bypass mode, 25h is a single write.
- R10: Any write that does not fit the current step of a sequence pulses `err_stb` one cycle later, produces no other strobe, and returns to the idle point of the current mode. A correct sequence that follows works from its first write.
- R11: Command codes are compared on data bits [7:0] only. The 555h and 2AAh checks compare only address bits [11:0].
- R12: The acceleration input passes through a two-stage synchroniser and sets `bypass_mode` within four cycles. After the input falls, `bypass_mode` stays high while `op_busy` is high. It clears once `op_busy` is low, and the release also cancels bypass entered by a write sequence.
- R13: While `op_busy` is high, a write that is not a step of an abort reset has no effect: no strobe, no error, and no change of sequence position.
- R14: At most one of the four strobes is high in any cycle, and each strobe follows an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write present |
| wr_ready | output | 1 | Write accepted (always high) |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Data of the write |
| op_busy | input | 1 | Embedded operation in progress |
| acc_req | input | 1 | Acceleration request, asynchronous |
| pgm_stb | output | 1 | Program command strobe |
| pgm_addr | output | ADDR_W | Program target address |
| pgm_data | output | DATA_W | Program data |
| bufld_stb | output | 1 | Write-buffer load start strobe |
| bufld_addr | output | ADDR_W | Address of the buffer load command |
| abort_stb | output | 1 | Abort reset strobe |
| err_stb | output | 1 | Illegal sequence strobe |
| bypass_mode | output | 1 | Bypass mode active |

## Verification
The bench builds the decoder with its default parameters: a 23-bit word address, 16-bit data, a 12-bit unlock compare and two synchroniser stages. The 23-bit address leaves bits above the compare window free. This lets the bench write unlock values at aliased addresses such as 3555h and confirm they still match, and lets program targets sit far above the unlock range. The two synchroniser stages keep the acceleration latency short enough to observe both the forced entry and the busy-gated release within a few cycles.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int unsigned CMD_W  = 8;
  localparam int unsigned NCODES = 8;

  // Index of each command code in the match vector
  localparam int unsigned IX_AA = 0;
  localparam int unsigned IX_55 = 1;
  localparam int unsigned IX_A0 = 2;
  localparam int unsigned IX_20 = 3;
  localparam int unsigned IX_25 = 4;
  localparam int unsigned IX_F0 = 5;
  localparam int unsigned IX_90 = 6;
  localparam int unsigned IX_00 = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UL1,
    ST_UL2,
    ST_PGM,
    ST_EXIT
  } seq_state_e;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_PGM,
    EV_BUF,
    EV_ABORT,
    EV_ERR
  } seq_event_e;

  typedef struct packed {
    logic at_first;   // low address bits equal the first unlock address
    logic at_second;  // low address bits equal the second unlock address
    logic d_aa;
    logic d_55;
    logic d_a0;
    logic d_20;
    logic d_25;
    logic d_f0;
    logic d_90;
    logic d_00;
  } wr_class_t;

  function automatic logic [CMD_W-1:0] code_at(input int unsigned idx);
    case (idx)
      IX_AA:   code_at = 8'hAA;
      IX_55:   code_at = 8'h55;
      IX_A0:   code_at = 8'hA0;
      IX_20:   code_at = 8'h20;
      IX_25:   code_at = 8'h25;
      IX_F0:   code_at = 8'hF0;
      IX_90:   code_at = 8'h90;
      default: code_at = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/fcd_classify.sv
module fcd_classify
  import flash_cmd_pkg::*;
#(
  parameter int unsigned CMP_W = 12,
  parameter logic [CMP_W-1:0] UNLK_FIRST  = 12'h555,
  parameter logic [CMP_W-1:0] UNLK_SECOND = 12'h2AA
) (
  input  logic [CMP_W-1:0] addr_lo,
  input  logic [CMD_W-1:0] cmd,
  output wr_class_t        cls
);

  logic [NCODES-1:0] hit;

  for (genvar gi = 0; gi < NCODES; gi++) begin : g_code
    assign hit[gi] = (cmd == code_at(gi));
  end

  always_comb begin
    cls.at_first  = (addr_lo == UNLK_FIRST);
    cls.at_second = (addr_lo == UNLK_SECOND);
    cls.d_aa      = hit[IX_AA];
    cls.d_55      = hit[IX_55];
    cls.d_a0      = hit[IX_A0];
    cls.d_20      = hit[IX_20];
    cls.d_25      = hit[IX_25];
    cls.d_f0      = hit[IX_F0];
    cls.d_90      = hit[IX_90];
    cls.d_00      = hit[IX_00];
  end

endmodule

// File: rtl/fcd_accel.sv
module fcd_accel #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_req,
  input  logic op_busy,
  output logic hold,
  output logic hold_set,
  output logic hold_clr
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   acc_s;

  for (genvar gs = 0; gs < SYNC_STAGES; gs++) begin : g_sync
    if (gs == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= acc_req;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[gs] <= 1'b0;
        else        sync_q[gs] <= sync_q[gs-1];
      end
    end
  end

  assign acc_s    = sync_q[SYNC_STAGES-1];
  assign hold_set = acc_s & ~hold;
  assign hold_clr = ~acc_s & hold & ~op_busy;

  always_ff @(posedge clk) begin
    if (!rst_n)        hold <= 1'b0;
    else if (hold_set) hold <= 1'b1;
    else if (hold_clr) hold <= 1'b0;
  end

endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 23,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  wr_class_t         cls,
  input  logic              op_busy,
  input  logic              hold,
  input  logic              hold_set,
  input  logic              hold_clr,
  output logic              pgm_stb,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [DATA_W-1:0] pgm_data,
  output logic              buf_stb,
  output logic [ADDR_W-1:0] buf_addr,
  output logic              abort_stb,
  output logic              err_stb,
  output logic              byp_sw
);

  seq_state_e st_q, st_d;
  seq_event_e ev;
  logic       byp_d, eff_byp, abort_path, take;

  always_comb begin
    eff_byp    = byp_sw | hold;
    abort_path = ((st_q == ST_IDLE) && cls.at_first && cls.d_aa)
              || ((st_q == ST_UL1) && cls.at_second && cls.d_55)
              || ((st_q == ST_UL2) && cls.d_f0)
              || ((st_q == ST_IDLE) && !eff_byp && cls.d_f0);
    take  = wr_fire && (!op_busy || abort_path);
    st_d  = st_q;
    byp_d = byp_sw;
    ev    = EV_NONE;
    if (hold_clr) begin
      st_d  = ST_IDLE;
      byp_d = 1'b0;
    end else if (hold_set) begin
      st_d = ST_IDLE;
    end else if (take) begin
      case (st_q)
        ST_IDLE: begin
          if (cls.at_first && cls.d_aa)  st_d = ST_UL1;
          else if (!eff_byp)             ev = cls.d_f0 ? EV_ABORT : EV_ERR;
          else if (cls.d_a0)             st_d = ST_PGM;
          else if (cls.d_25)             ev = EV_BUF;
          else if (cls.d_90)             st_d = ST_EXIT;
          else                           ev = EV_ERR;
        end
        ST_UL1: begin
          if (cls.at_second && cls.d_55) st_d = ST_UL2;
          else begin
            st_d = ST_IDLE;
            ev   = EV_ERR;
          end
        end
        ST_UL2: begin
          st_d = ST_IDLE;
          if (cls.d_f0)                       ev = EV_ABORT;
          else if (eff_byp)                   ev = EV_ERR;
          else if (cls.at_first && cls.d_a0)  st_d = ST_PGM;
          else if (cls.at_first && cls.d_20)  byp_d = 1'b1;
          else if (cls.d_25)                  ev = EV_BUF;
          else                                ev = EV_ERR;
        end
        ST_PGM: begin
          st_d = ST_IDLE;
          ev   = EV_PGM;
        end
        ST_EXIT: begin
          st_d = ST_IDLE;
          if (cls.d_00) byp_d = 1'b0;
          else          ev = EV_ERR;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      byp_sw    <= 1'b0;
      pgm_stb   <= 1'b0;
      buf_stb   <= 1'b0;
      abort_stb <= 1'b0;
      err_stb   <= 1'b0;
      pgm_addr  <= '0;
      pgm_data  <= '0;
      buf_addr  <= '0;
    end else begin
      st_q      <= st_d;
      byp_sw    <= byp_d;
      pgm_stb   <= (ev == EV_PGM);
      buf_stb   <= (ev == EV_BUF);
      abort_stb <= (ev == EV_ABORT);
      err_stb   <= (ev == EV_ERR);
      if (ev == EV_PGM) begin
        pgm_addr <= wr_addr;
        pgm_data <= wr_data;
      end
      if (ev == EV_BUF) buf_addr <= wr_addr;
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 23,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CMP_W       = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              op_busy,
  input  logic              acc_req,
  output logic              pgm_stb,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [DATA_W-1:0] pgm_data,
  output logic              bufld_stb,
  output logic [ADDR_W-1:0] bufld_addr,
  output logic              abort_stb,
  output logic              err_stb,
  output logic              bypass_mode
);

  localparam logic [CMP_W-1:0] UNLK_FIRST  = CMP_W'('h555);
  localparam logic [CMP_W-1:0] UNLK_SECOND = CMP_W'('h2AA);

  wr_class_t cls;
  logic      hold, hold_set, hold_clr, byp_sw;

  assign wr_ready = 1'b1;

  fcd_classify #(
    .CMP_W      (CMP_W),
    .UNLK_FIRST (UNLK_FIRST),
    .UNLK_SECOND(UNLK_SECOND)
  ) u_classify (
    .addr_lo(wr_addr[CMP_W-1:0]),
    .cmd    (wr_data[CMD_W-1:0]),
    .cls    (cls)
  );

  fcd_accel #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_accel (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_req (acc_req),
    .op_busy (op_busy),
    .hold    (hold),
    .hold_set(hold_set),
    .hold_clr(hold_clr)
  );

  fcd_seq #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_fire  (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cls      (cls),
    .op_busy  (op_busy),
    .hold     (hold),
    .hold_set (hold_set),
    .hold_clr (hold_clr),
    .pgm_stb  (pgm_stb),
    .pgm_addr (pgm_addr),
    .pgm_data (pgm_data),
    .buf_stb  (bufld_stb),
    .buf_addr (bufld_addr),
    .abort_stb(abort_stb),
    .err_stb  (err_stb),
    .byp_sw   (byp_sw)
  );

  assign bypass_mode = byp_sw | hold;

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
  input logic clk,
  input logic rst_n,
  input logic wr_valid,
  input logic op_busy,
  input logic pgm_stb,
  input logic bufld_stb,
  input logic abort_stb,
  input logic err_stb
);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pgm_stb, bufld_stb, abort_stb, err_stb})); // R14

  AST_STROBE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_stb || bufld_stb || abort_stb || err_stb) |-> $past(wr_valid)); // R14

  AST_PGM_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_stb |=> !pgm_stb); // R2

  AST_BUSY_NO_PGM: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_stb |-> !$past(op_busy)); // R13

  AST_BUSY_NO_BUFLD: assert property (@(posedge clk) disable iff (!rst_n)
    bufld_stb |-> !$past(op_busy)); // R13

endmodule

bind flash_cmd_decoder fcd_checker u_fcd_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .op_busy  (op_busy),
  .pgm_stb  (pgm_stb),
  .bufld_stb(bufld_stb),
  .abort_stb(abort_stb),
  .err_stb  (err_stb)
);

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;

  localparam int unsigned AW = 23;
  localparam int unsigned DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          op_busy = 1'b0;
  logic          acc_req = 1'b0;
  logic          pgm_stb, bufld_stb, abort_stb, err_stb, bypass_mode;
  logic [AW-1:0] pgm_addr, bufld_addr;
  logic [DW-1:0] pgm_data;

  int checks = 0;
  int errors = 0;

  // observed after each write
  int            o_kind;
  int            o_count;
  logic [AW-1:0] o_paddr, o_baddr;
  logic [DW-1:0] o_pdata;

  // reference model state
  int m_st;   // 0 idle 1 ul1 2 ul2 3 pgm 4 exit
  bit m_byp;

  always #4 clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .op_busy(op_busy), .acc_req(acc_req),
    .pgm_stb(pgm_stb), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
    .bufld_stb(bufld_stb), .bufld_addr(bufld_addr), .abort_stb(abort_stb),
    .err_stb(err_stb), .bypass_mode(bypass_mode)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    o_count = int'(pgm_stb) + int'(bufld_stb) + int'(abort_stb) + int'(err_stb);
    o_kind  = pgm_stb ? 1 : bufld_stb ? 2 : abort_stb ? 3 : err_stb ? 4 : 0;
    o_paddr = pgm_addr; o_pdata = pgm_data; o_baddr = bufld_addr;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    m_st = 0; m_byp = 1'b0;
  endtask

  // expected strobe kind per the requirements: 0 none 1 pgm 2 buf 3 abort 4 err
  function automatic int model_step(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bit f = (a[11:0] == 12'h555);
    bit s = (a[11:0] == 12'h2AA);
    logic [7:0] c = d[7:0];
    int k = 0;
    case (m_st)
      0: begin
        if (f && c == 8'hAA) m_st = 1;
        else if (!m_byp) k = (c == 8'hF0) ? 3 : 4;
        else if (c == 8'hA0) m_st = 3;
        else if (c == 8'h25) k = 2;
        else if (c == 8'h90) m_st = 4;
        else k = 4;
      end
      1: begin
        if (s && c == 8'h55) m_st = 2;
        else begin m_st = 0; k = 4; end
      end
      2: begin
        m_st = 0;
        if (c == 8'hF0) k = 3;
        else if (m_byp) k = 4;
        else if (f && c == 8'hA0) m_st = 3;
        else if (f && c == 8'h20) m_byp = 1'b1;
        else if (c == 8'h25) k = 2;
        else k = 4;
      end
      3: begin m_st = 0; k = 1; end
      default: begin
        m_st = 0;
        if (c == 8'h00) m_byp = 1'b0; else k = 4;
      end
    endcase
    return k;
  endfunction

  task automatic unlock2();
    wr(23'h555, 16'h00AA);
    wr(23'h2AA, 16'h0055);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [AW-1:0] ra;
    logic [DW-1:0] rd;
    int            ek;
    void'($urandom(32'd4711));
    do_reset();

    // R1 reset state
    chk("R1 strobes", {pgm_stb, bufld_stb, abort_stb, err_stb}, 0);
    chk("R1 bypass", bypass_mode, 0);
    chk("R1 ready", wr_ready, 1);

    // R2 normal program
    unlock2();
    chk("R2 no strobe on unlock", o_count, 0);
    wr(23'h555, 16'h00A0);
    chk("R2 no strobe on cmd", o_count, 0);
    wr(23'h12345, 16'hBEEF);
    chk("R2 pgm", o_kind, 1);
    chk("R2 addr", o_paddr, 23'h12345);
    chk("R2 data", o_pdata, 16'hBEEF);

    // R8 lone reset and three-write reset in normal mode
    wr(23'h7, 16'h00F0);
    chk("R8 lone F0", o_kind, 3);
    unlock2(); wr(23'h31, 16'h00F0);
    chk("R8 unlocked F0", o_kind, 3);

    // R10 broken sequence then recovery
    wr(23'h555, 16'h00AA);
    wr(23'h2AA, 16'h0056);
    chk("R10 err", o_kind, 4);
    chk("R10 single strobe", o_count, 1);
    unlock2(); wr(23'h555, 16'h00A0); wr(23'h40, 16'h0001);
    chk("R10 recovery pgm", o_kind, 1);

    // R11 aliased addresses and upper data byte ignored
    wr(23'h3555, 16'h77AA); wr(23'h12AA, 16'h1255); wr(23'h7F555, 16'hFFA0);
    wr(23'h400000, 16'h5A5A);
    chk("R11 alias pgm", o_kind, 1);
    chk("R11 alias addr", o_paddr, 23'h400000);

    // R9 buffer load in normal mode
    unlock2(); wr(23'h4000, 16'h0025);
    chk("R9 normal buf", o_kind, 2);
    chk("R9 normal buf addr", o_baddr, 23'h4000);

    // R3 bypass entry
    unlock2();
    chk("R3 still normal", bypass_mode, 0);
    wr(23'h555, 16'h0020);
    chk("R3 entered", bypass_mode, 1);
    chk("R3 no strobe", o_count, 0);

    // R4 bypass program
    wr(23'h777, 16'h00A0);
    chk("R4 no strobe on cmd", o_count, 0);
    wr(23'h100, 16'h1234);
    chk("R4 pgm", o_kind, 1);
    chk("R4 data", o_pdata, 16'h1234);

    // R9 buffer load in bypass
    wr(23'h8000, 16'h0025);
    chk("R9 bypass buf", o_kind, 2);
    chk("R9 bypass buf addr", o_baddr, 23'h8000);

    // R6 rejected commands in bypass
    wr(23'h0, 16'h00F0);
    chk("R6 lone F0 err", o_kind, 4);
    wr(23'h0, 16'h0080);
    chk("R6 other err", o_kind, 4);
    chk("R6 bypass kept", bypass_mode, 1);

    // R7 three-write abort in bypass
    unlock2(); wr(23'h99, 16'h00F0);
    chk("R7 abort", o_kind, 3);
    chk("R7 bypass kept", bypass_mode, 1);

    // R5 bypass exit
    wr(23'h2000, 16'h0090); wr(23'h1, 16'h0011);
    chk("R5 bad exit err", o_kind, 4);
    chk("R5 bad exit keeps", bypass_mode, 1);
    wr(23'h2000, 16'h0090); wr(23'h1, 16'h0000);
    chk("R5 exit", bypass_mode, 0);

    // R13 busy gating
    op_busy = 1'b1;
    wr(23'h0, 16'h0033);
    chk("R13 ignored while busy", o_count, 0);
    wr(23'h0, 16'h00F0);
    chk("R13 abort while busy", o_kind, 3);
    op_busy = 1'b0;
    unlock2(); wr(23'h555, 16'h00A0);
    op_busy = 1'b1;
    wr(23'h55, 16'h1111);
    chk("R13 target ignored", o_count, 0);
    op_busy = 1'b0;
    wr(23'h66, 16'h2222);
    chk("R13 pgm after busy", o_kind, 1);
    chk("R13 pgm addr", o_paddr, 23'h66);

    // R12 acceleration
    acc_req = 1'b1; idle(5);
    chk("R12 forced bypass", bypass_mode, 1);
    wr(23'h0, 16'h00A0); wr(23'h200, 16'hABCD);
    chk("R12 short pgm", o_kind, 1);
    op_busy = 1'b1; acc_req = 1'b0; idle(6);
    chk("R12 held while busy", bypass_mode, 1);
    op_busy = 1'b0; idle(4);
    chk("R12 released", bypass_mode, 0);
    unlock2(); wr(23'h555, 16'h0020);
    chk("R12 sw bypass", bypass_mode, 1);
    acc_req = 1'b1; idle(5); acc_req = 1'b0; idle(6);
    chk("R12 release clears sw", bypass_mode, 0);
    wr(23'h0, 16'h00F0);
    chk("R12 normal after release", o_kind, 3);

    // constrained random against the model (R10, R14)
    do_reset();
    for (int n = 0; n < 3000; n++) begin
      int pa = $urandom_range(0, 3);
      int pd = $urandom_range(0, 9);
      ra = AW'($urandom());
      if (pa == 0) ra[11:0] = 12'h555;
      else if (pa == 1) ra[11:0] = 12'h2AA;
      rd = DW'($urandom());
      case (pd)
        0: rd[7:0] = 8'hAA; 1: rd[7:0] = 8'h55; 2: rd[7:0] = 8'hA0;
        3: rd[7:0] = 8'h20; 4: rd[7:0] = 8'h25; 5: rd[7:0] = 8'hF0;
        6: rd[7:0] = 8'h90; 7: rd[7:0] = 8'h00; default: ;
      endcase
      ek = model_step(ra, rd);
      wr(ra, rd);
      chk("R10 random kind", o_kind, ek);
      chk("R14 random count", o_count, (ek == 0) ? 0 : 1);
      chk("R3 random mode", bypass_mode, m_byp);
      if (ek == 1) begin
        chk("R2 random paddr", o_paddr, ra);
        chk("R2 random pdata", o_pdata, rd);
      end
      if (ek == 2) chk("R9 random baddr", o_baddr, ra);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule